// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves blocks of bytes between up to four peripherals and memory without CPU involvement. Before any transfer the CPU programs it through a byte-wide slave port. Each channel has a 16-bit start address and a 16-bit byte count, and a mode byte sets the channel enables, the arbitration scheme and the transfer direction. When an enabled peripheral raises its request line, the controller asks the CPU for the system bus with a hold request. It waits for the hold acknowledge, then runs one bus cycle per byte: it drives the memory address, the memory and I/O strobes and the serviced channel's active-low acknowledge.

Each byte takes one address phase and one strobe phase. In the address phase the upper address byte is placed on the data output and an address strobe pulses so that an external latch can capture it. The lower byte stays on the dedicated address outputs through both phases. After each byte the channel's address counts up and its count counts down. When a byte is moved with the count at zero, the channel has reached terminal count. It then raises a sticky status bit and switches itself off.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset the mode byte, the status flags, every address and count register and the byte pointer are zero, and the rotating priority pointer selects channel 0 as highest. holdReq is low, all dackN are high, all four strobes are high and addrStrobe is low, even with requests present.
- R2: An enabled channel with dreq high makes holdReq rise on the next clock. No acknowledge, strobe or address strobe is driven until holdAck has been sampled high.
- R3: Offset 2k selects channel k's address register and offset 2k+1 its count register. Each 16-bit register is accessed as two single-cycle byte accesses, low byte first, through a shared byte pointer. The pointer toggles on every channel register access and is cleared by reset and by any mode write.
- R4: Offset 8 writes the mode byte: bits 3:0 enable channels 0 to 3, bit 4 selects rotating priority, and bit 5 selects the direction. With bit 5 at 1 (peripheral to memory) the strobe phase pulls memWrN and ioRdN low. With bit 5 at 0 it pulls memRdN and ioWrN low. Only one of memRdN and memWrN is ever low.
- R5: Each byte takes two cycles. The first has addrStrobe high with address[15:8] on dataOut and address[7:0] on addrLo. The second is the strobe phase. dackN is low only for the serviced channel during both cycles.
- R6: After each byte the serviced channel's address increases by one and its count decreases by one, both wrapping at 16 bits.
- R7: A channel loaded with count N-1 moves exactly N bytes. The byte moved at count zero sets its status bit (bit k for channel k) and clears its enable bit.
- R8: A read of offset 8 returns the terminal-count flags in bits 3:0 and zeros above, then clears them. A flag is never cleared in any other way except reset.
- R9: With fixed priority, the lowest-numbered pending channel is served first.
- R10: With rotating priority, the channel after the last one served is highest, and the search wraps from channel 3 to channel 0.
- R11: holdReq drops one cycle after a byte completes if no enabled request is pending.
- R12: Slave writes and reads have no effect while holdReq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Slave port select, active low |
| rdN | input | 1 | Slave read strobe, active low |
| wrN | input | 1 | Slave write strobe, active low |
| regAddr | input | 4 | Slave register offset |
| dataIn | input | 8 | Slave write data |
| dataOut | output | 8 | Slave read data, or upper address byte during the address phase |
| dreq | input | 4 | Per-channel transfer request |
| dackN | output | 4 | Per-channel acknowledge, active low |
| holdReq | output | 1 | Bus request to the CPU |
| holdAck | input | 1 | Bus grant from the CPU |
| addrLo | output | 8 | Lower memory address byte |
| addrStrobe | output | 1 | Pulse that marks the upper address byte on dataOut |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| ioRdN | output | 1 | Peripheral read strobe, active low |
| ioWrN | output | 1 | Peripheral write strobe, active low |

## Verification
A corrupted address or count register shows up in the very next address phase as a wrong value on dataOut/addrLo. A wrong count also shows up later as a byte too many or too few before holdReq drops. An arbitration pointer that is off by one changes which dackN line falls at the next grant, so the order of channels in the scoreboard exposes it within one byte time. A terminal-count flag that is lost or cleared early appears at the first status read after the block, and a leftover enable keeps holdReq high with the request line still raised.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  parameter int DMA_CH = 4;
  localparam int DMA_CH_W = $clog2(DMA_CH);
  localparam int DMA_RA_W = $clog2(2 * DMA_CH + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ADDR = 2'd2,
    ST_XFER = 2'd3
  } busState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic                step;
    logic [DMA_CH_W-1:0] chan;
  } xferStrb_t;
endpackage

// File: rtl/dma4_datapath.sv
module dma4_datapath
  import dma4_pkg::*;
#(
  parameter int NUM_CH = DMA_CH,
  parameter int ADDR_W = 16,
  parameter int RA_W   = DMA_RA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveEn,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        rdData,
  input  xferStrb_t         strb,
  output logic [NUM_CH-1:0] enables,
  output logic              rotate,
  output logic              dirWrite,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int MODE_OFF = 2 * NUM_CH;
  localparam int ROT_BIT  = NUM_CH;
  localparam int DIR_BIT  = NUM_CH + 1;
  localparam int MODE_W   = NUM_CH + 2;
  localparam int HI       = ADDR_W - 1;

  logic [ADDR_W-1:0] addrReg [NUM_CH];
  logic [ADDR_W-1:0] cntReg  [NUM_CH];
  logic [MODE_W-1:0] modeReg;
  logic [NUM_CH-1:0] tcFlags;
  logic              bytePtr;

  logic              wrAcc, rdAcc, isMode, isChan, isCnt;
  logic [CH_W-1:0]   chSel;
  logic [ADDR_W-1:0] selWord, curCnt;

  assign wrAcc  = slaveEn && !csN && !wrN;
  assign rdAcc  = slaveEn && !csN && !rdN && wrN;
  assign isMode = (regAddr == RA_W'(MODE_OFF));
  assign isChan = (regAddr < RA_W'(MODE_OFF));
  assign isCnt  = regAddr[0];
  assign chSel  = regAddr[CH_W:1];

  assign enables  = modeReg[NUM_CH-1:0];
  assign rotate   = modeReg[ROT_BIT];
  assign dirWrite = modeReg[DIR_BIT];
  assign curAddr  = addrReg[strb.chan];
  assign curCnt   = cntReg[strb.chan];

  assign selWord = isCnt ? cntReg[chSel] : addrReg[chSel];

  always_comb begin
    rdData = '0;
    if (rdAcc) begin
      if (isMode)      rdData = 8'(tcFlags);
      else if (isChan) rdData = bytePtr ? selWord[HI:8] : selWord[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        addrReg[c] <= '0;
        cntReg[c]  <= '0;
      end
      modeReg <= '0;
      tcFlags <= '0;
      bytePtr <= 1'b0;
    end else begin
      if (wrAcc) begin
        if (isMode) begin
          modeReg <= dataIn[MODE_W-1:0];
          bytePtr <= 1'b0;
        end else if (isChan) begin
          for (int c = 0; c < NUM_CH; c++) begin
            if (chSel == CH_W'(c)) begin
              if (isCnt) begin
                if (bytePtr) cntReg[c][HI:8] <= dataIn;
                else         cntReg[c][7:0]  <= dataIn;
              end else begin
                if (bytePtr) addrReg[c][HI:8] <= dataIn;
                else         addrReg[c][7:0]  <= dataIn;
              end
            end
          end
          bytePtr <= ~bytePtr;
        end
      end else if (rdAcc) begin
        if (isMode)      tcFlags <= '0;
        else if (isChan) bytePtr <= ~bytePtr;
      end
      if (strb.step) begin
        addrReg[strb.chan] <= curAddr + 1'b1;
        cntReg[strb.chan]  <= curCnt - 1'b1;
        if (curCnt == '0) begin
          tcFlags[strb.chan] <= 1'b1;
          modeReg[strb.chan] <= 1'b0;
        end
      end
    end
  end

  AST_ADDR_INC: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> addrReg[$past(strb.chan)] == $past(curAddr) + 1'b1); // R6
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> cntReg[$past(strb.chan)] == $past(curCnt) - 1'b1); // R6
  AST_TC_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && curCnt == '0) |=> (tcFlags[$past(strb.chan)] && !modeReg[$past(strb.chan)])); // R7
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(rdAcc && isMode) |=> (($past(tcFlags) & ~tcFlags) == '0)); // R8
endmodule

// File: rtl/dma4_control.sv
module dma4_control
  import dma4_pkg::*;
#(
  parameter int NUM_CH = DMA_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] dreq,
  input  logic              holdAck,
  input  logic [NUM_CH-1:0] enables,
  input  logic              rotate,
  output busState_t         state,
  output xferStrb_t         strb,
  output logic              holdReq,
  output logic              slaveEn
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0] pending;
  logic [CH_W-1:0]   grant, prioPtr, base, arbChan;
  logic              arbHit;

  assign pending = dreq & enables;
  assign base    = rotate ? prioPtr : '0;

  always_comb begin
    arbHit  = 1'b0;
    arbChan = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      logic [CH_W-1:0] idx;
      idx = CH_W'((int'(base) + i) % NUM_CH);
      if (!arbHit && pending[idx]) begin
        arbHit  = 1'b1;
        arbChan = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      grant   <= '0;
      prioPtr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (arbHit) state <= ST_WAIT;
        ST_WAIT: begin
          if (!arbHit) state <= ST_IDLE;
          else if (holdAck) begin
            state <= ST_ADDR;
            grant <= arbChan;
          end
        end
        ST_ADDR: state <= ST_XFER;
        ST_XFER: begin
          state   <= ST_WAIT;
          prioPtr <= CH_W'((int'(grant) + 1) % NUM_CH);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign holdReq   = (state != ST_IDLE);
  assign slaveEn   = (state == ST_IDLE);
  assign strb.step = (state == ST_XFER);
  assign strb.chan = grant;

  AST_ACK_BEFORE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR) |-> $past(holdAck)); // R2
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR) |-> ((($past(pending)) >> grant) & 1) != 0); // R9
  AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && pending == '0) |=> !holdReq); // R11
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NUM_CH = DMA_CH,
  parameter int ADDR_W = 16,
  parameter int RA_W   = DMA_RA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  input  logic [NUM_CH-1:0] dreq,
  output logic [NUM_CH-1:0] dackN,
  output logic              holdReq,
  input  logic              holdAck,
  output logic [7:0]        addrLo,
  output logic              addrStrobe,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN
);
  busState_t         state;
  xferStrb_t         strb;
  logic              slaveEn, rotate, dirWrite, busy, xfer;
  logic [NUM_CH-1:0] enables;
  logic [7:0]        rdData;
  logic [ADDR_W-1:0] curAddr;

  dma4_control #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rstN(rstN), .dreq(dreq), .holdAck(holdAck),
    .enables(enables), .rotate(rotate), .state(state), .strb(strb),
    .holdReq(holdReq), .slaveEn(slaveEn)
  );

  dma4_datapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .RA_W(RA_W)) dp_i (
    .clk(clk), .rstN(rstN), .slaveEn(slaveEn), .csN(csN), .rdN(rdN),
    .wrN(wrN), .regAddr(regAddr), .dataIn(dataIn), .rdData(rdData),
    .strb(strb), .enables(enables), .rotate(rotate), .dirWrite(dirWrite),
    .curAddr(curAddr)
  );

  assign busy       = (state == ST_ADDR) || (state == ST_XFER);
  assign xfer       = (state == ST_XFER);
  assign addrStrobe = (state == ST_ADDR);
  assign dataOut    = addrStrobe ? curAddr[ADDR_W-1:8] : rdData;
  assign addrLo     = busy ? curAddr[7:0] : '0;
  assign dackN      = busy ? ~(NUM_CH'(1) << strb.chan) : '1;
  assign memRdN     = !(xfer && !dirWrite);
  assign ioWrN      = !(xfer && !dirWrite);
  assign memWrN     = !(xfer && dirWrite);
  assign ioRdN      = !(xfer && dirWrite);

  AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~dackN)); // R5
  AST_DACK_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dackN != '1) |-> holdReq); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~memRdN, ~memWrN}) <= 1); // R4
  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    !memWrN |-> (!ioRdN && ioWrN && dackN != '1)); // R4
endmodule

// File: tb/dma4_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma4_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [3:0] regAddr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic [3:0] dreq = '0;
  logic [3:0] dackN;
  logic       holdReq, holdAck = 1'b0, ackEn = 1'b0;
  logic [7:0] addrLo;
  logic       addrStrobe, memRdN, memWrN, ioRdN, ioWrN;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int          chan;
    logic [15:0] addr;
    bit          dirW;
  } expItem_t;
  expItem_t expQ[$];

  bit         strbPhase = 0;
  bit         lastDir;
  logic [3:0] lastDack;

  always #2.5 clk = ~clk;

  dma4_ctrl dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .regAddr(regAddr), .dataIn(dataIn), .dataOut(dataOut),
    .dreq(dreq), .dackN(dackN), .holdReq(holdReq), .holdAck(holdAck),
    .addrLo(addrLo), .addrStrobe(addrStrobe), .memRdN(memRdN),
    .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pops expected bus cycles and compares them
  always @(negedge clk) begin
    holdAck <= ackEn & holdReq;
    if (rstN) begin
      if (strbPhase) begin
        strbPhase = 0;
        chk(dackN == lastDack, "R5 dack held in strobe phase", dackN, lastDack);
        chk({memRdN, memWrN, ioRdN, ioWrN} == (lastDir ? 4'b1001 : 4'b0110),
            "R4 strobe pattern", {memRdN, memWrN, ioRdN, ioWrN},
            lastDir ? 4'b1001 : 4'b0110);
      end
      if (addrStrobe) begin
        if (expQ.size() == 0) begin
          chk(0, "R7 unexpected extra byte", {dataOut, addrLo}, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(dackN == ~(4'b1 << e.chan), "R9 R10 serviced channel",
              dackN, ~(4'b1 << e.chan));
          chk({dataOut, addrLo} == e.addr, "R6 byte address",
              {dataOut, addrLo}, e.addr);
          chk({memRdN, memWrN} == 2'b11, "R5 no strobe in address phase",
              {memRdN, memWrN}, 2'b11);
          lastDack  = ~(4'b1 << e.chan);
          lastDir   = e.dirW;
          strbPhase = 1;
        end
      end
    end
  end

  // driver tasks
  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    csN = 0; wrN = 0; regAddr = a; dataIn = d;
    @(negedge clk);
    csN = 1; wrN = 1;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    csN = 0; rdN = 0; regAddr = a;
    #1 d = dataOut;
    @(negedge clk);
    csN = 1; rdN = 1;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wrReg(a, v[7:0]);
    wrReg(a, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rdReg(a, lo);
    rdReg(a, hi);
    v = {hi, lo};
  endtask

  task automatic push(input int ch, input logic [15:0] a, input bit dw);
    expItem_t e;
    e.chan = ch; e.addr = a; e.dirW = dw;
    expQ.push_back(e);
  endtask

  task automatic waitDone(input string tag);
    int n;
    n = 0;
    while ((holdReq || expQ.size() != 0 || strbPhase) && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0 && !holdReq, tag, {expQ.size(), holdReq}, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; ackEn = 0; dreq = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;

    doReset();
    // reset state
    @(negedge clk);
    chk(holdReq == 0 && dackN == 4'hF && addrStrobe == 0, "R1 reset outputs",
        {holdReq, dackN, addrStrobe}, {1'b0, 4'hF, 1'b0});
    chk({memRdN, memWrN, ioRdN, ioWrN} == 4'hF, "R1 reset strobes",
        {memRdN, memWrN, ioRdN, ioWrN}, 4'hF);
    rdReg(4'd8, b);
    chk(b == 8'h00, "R1 status after reset", b, 8'h00);
    dreq = 4'hF;
    repeat (5) @(negedge clk);
    chk(holdReq == 0, "R1 channels disabled after reset", holdReq, 0);
    dreq = '0;

    // single channel, peripheral to memory, address crosses a byte boundary
    wr16(4'd0, 16'h12FE);
    wr16(4'd1, 16'h0002);
    rd16(4'd0, w);
    chk(w == 16'h12FE, "R3 address readback", w, 16'h12FE);
    rd16(4'd1, w);
    chk(w == 16'h0002, "R3 count readback", w, 16'h0002);
    push(0, 16'h12FE, 1); push(0, 16'h12FF, 1); push(0, 16'h1300, 1);
    dreq = 4'b0001;
    wrReg(4'd8, 8'h21);
    repeat (4) @(negedge clk);
    chk(holdReq == 1 && dackN == 4'hF && addrStrobe == 0,
        "R2 hold raised, bus idle without ack", {holdReq, dackN, addrStrobe},
        {1'b1, 4'hF, 1'b0});
    ackEn = 1;
    waitDone("R7 R11 three bytes then hold dropped");
    chk(dreq[0] == 1 && holdReq == 0, "R7 channel stopped with request high",
        holdReq, 0);
    rdReg(4'd8, b);
    chk(b == 8'h01, "R8 status after terminal count", b, 8'h01);
    rdReg(4'd8, b);
    chk(b == 8'h00, "R8 status cleared by read", b, 8'h00);
    rd16(4'd0, w);
    chk(w == 16'h1301, "R6 final address", w, 16'h1301);
    rd16(4'd1, w);
    chk(w == 16'hFFFF, "R6 count past zero", w, 16'hFFFF);
    dreq = '0;

    // fixed priority, memory to peripheral
    wr16(4'd2, 16'h2000); wr16(4'd3, 16'h0001);
    wr16(4'd4, 16'h3000); wr16(4'd5, 16'h0000);
    push(1, 16'h2000, 0); push(1, 16'h2001, 0); push(2, 16'h3000, 0);
    dreq = 4'b0110;
    wrReg(4'd8, 8'h06);
    waitDone("R9 fixed priority order complete");
    rdReg(4'd8, b);
    chk(b == 8'h06, "R8 status two channels", b, 8'h06);
    dreq = '0;

    // rotating priority from a fresh reset
    doReset();
    rd16(4'd2, w);
    chk(w == 16'h0000, "R1 address register cleared", w, 16'h0000);
    wr16(4'd0, 16'h4000); wr16(4'd1, 16'h0001);
    wr16(4'd2, 16'h5000); wr16(4'd3, 16'h0001);
    wr16(4'd6, 16'h6000); wr16(4'd7, 16'h0000);
    push(0, 16'h4000, 0); push(1, 16'h5000, 0); push(3, 16'h6000, 0);
    push(0, 16'h4001, 0); push(1, 16'h5001, 0);
    dreq = 4'b1011;
    ackEn = 1;
    wrReg(4'd8, 8'h1B);
    waitDone("R10 rotating order complete");
    rdReg(4'd8, b);
    chk(b == 8'h0B, "R8 status three channels", b, 8'h0B);
    dreq = '0;

    // slave access ignored while hold is requested
    ackEn = 0;
    wr16(4'd4, 16'h7000); wr16(4'd5, 16'h0003);
    dreq = 4'b0100;
    wrReg(4'd8, 8'h24);
    repeat (3) @(negedge clk);
    chk(holdReq == 1, "R2 hold pending", holdReq, 1);
    wrReg(4'd8, 8'h00);
    wrReg(4'd5, 8'h00);
    push(2, 16'h7000, 1); push(2, 16'h7001, 1);
    push(2, 16'h7002, 1); push(2, 16'h7003, 1);
    ackEn = 1;
    waitDone("R12 writes during hold had no effect");
    rd16(4'd5, w);
    chk(w == 16'hFFFF, "R12 count untouched by blocked write", w, 16'hFFFF);
    dreq = '0;

    // byte pointer cleared by mode write
    wrReg(4'd6, 8'hAA);
    wrReg(4'd8, 8'h00);
    wr16(4'd6, 16'h1234);
    rd16(4'd6, w);
    chk(w == 16'h1234, "R3 pointer cleared by mode write", w, 16'h1234);

    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule